// File: doc/BRIEF.md
# DMA Channel Interrupt Status Unit

This unit gathers completion and fault events from a sixteen-channel DMA engine and presents them to a processor. Each channel can raise four kinds of event, each as a single-cycle pulse: the end of a whole linked chain, the end of one node within the chain, and two separate fault causes. For every event kind the unit keeps a sticky per-channel latch, a per-channel enable mask and a masked view, which is the latch ANDed with the mask.

A processor reads and writes the unit through a plain valid/write/address/data port. Read data appears one cycle after the request. A latched event is acknowledged by writing ones to that kind's latch address. A summary word shows which channels have any enabled event pending, and one interrupt line goes high whenever any enabled event is pending. The port also reads back the channels' running flags and holds a channel priority word for the engine's arbiter.

Top module: `dmairq_top`

## Requirements
- R1: After reset every latch, every mask bit and the priority word are zero, `irq_o` is low and `rd_valid_o` is low.
- R2: A pulse on channel i of an event input sets latch bit i of that kind on the next clock edge. The bit stays set until it is cleared. The kinds are numbered chain-done 0, node-done 1, fault A 2 and fault B 3. Latch addresses are 0x600, 0x608, 0x610 and 0x618, in kind order.
- R3: A write to a latch address clears each bit whose write-data bit is 1. Bits written with 0 keep their value.
- R4: If an event pulse and a clearing write hit the same latch bit in the same cycle, the bit ends up set.
- R5: Mask registers sit at 0x018, 0x01C, 0x020 and 0x024, in kind order, and read back what was written. A mask bit of 1 enables that channel. The masked views at 0x004, 0x008, 0x00C and 0x010 read latch AND mask.
- R6: The summary word at 0x000 has bit i set exactly when channel i has an enabled pending event of any kind.
- R7: `irq_o` is high exactly when some masked bit of some kind is set.
- R8: A read request gives `rd_valid_o` high for exactly the next cycle. `rd_data_o` then holds the register value as it stood at the request edge. Writes give no `rd_valid_o`.
- R9: A read at 0x690 returns `busy_i` as it was sampled at the request edge.
- R10: The priority word at 0x688 reads back the last value written and has no effect on any latch or mask.
- R11: Writes to the summary, masked-view and busy addresses change nothing. Reads of unmapped addresses return 0.
- R12: A write to one kind's latch or mask changes no other kind's registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ev_chain_i | input | 16 | Per-channel chain-done pulses |
| ev_node_i | input | 16 | Per-channel node-done pulses |
| ev_err_a_i | input | 16 | Per-channel fault A pulses |
| ev_err_b_i | input | 16 | Per-channel fault B pulses |
| busy_i | input | 16 | Per-channel running flags |
| reg_valid_i | input | 1 | Register access request |
| reg_write_i | input | 1 | 1 = write, 0 = read |
| reg_addr_i | input | 12 | Byte address of the register |
| reg_wdata_i | input | 32 | Write data |
| rd_valid_o | output | 1 | Read data valid, one cycle after a read request |
| rd_data_o | output | 32 | Read data |
| irq_o | output | 1 | Combined interrupt request |

## Verification
The assertions check four things on every cycle. An event always lands in its latch, even when a clear hits the same bit. No latch bit rises without an event. The interrupt line always matches the enabled latches. Read-valid follows read requests with one cycle of delay. The bench scenarios show the rest: the register address map, that a clear with zeros does nothing, that the kinds are isolated from each other, that reads return values from the request edge, and that writes to read-only and unmapped addresses are ignored. Each of these is checked by reading registers back through the port.

// File: rtl/dmairq_pkg.sv
package dmairq_pkg;

    localparam int NUM_CLS = 4;
    localparam int REG_AW  = 12;

    typedef enum logic [1:0] {
        CLS_CHAIN = 2'd0,
        CLS_NODE  = 2'd1,
        CLS_ERR_A = 2'd2,
        CLS_ERR_B = 2'd3
    } ev_cls_e;

    localparam logic [REG_AW-1:0] OFS_SUMMARY   = 12'h000;
    localparam logic [REG_AW-1:0] OFS_STAT_BASE = 12'h004;
    localparam logic [REG_AW-1:0] OFS_MASK_BASE = 12'h018;
    localparam logic [REG_AW-1:0] OFS_RAW_BASE  = 12'h600;
    localparam logic [REG_AW-1:0] OFS_PRIO      = 12'h688;
    localparam logic [REG_AW-1:0] OFS_BUSY      = 12'h690;
    localparam int STAT_STRIDE = 4;
    localparam int RAW_STRIDE  = 8;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_SUMMARY,
        SEL_STAT,
        SEL_MASK,
        SEL_RAW,
        SEL_PRIO,
        SEL_BUSY
    } reg_sel_e;

    typedef struct packed {
        reg_sel_e   sel;
        logic [1:0] cls;
    } reg_dec_t;

    function automatic reg_dec_t decode_addr(input logic [REG_AW-1:0] a);
        reg_dec_t d;
        d.sel = SEL_NONE;
        d.cls = 2'd0;
        if (a == OFS_SUMMARY) d.sel = SEL_SUMMARY;
        if (a == OFS_PRIO)    d.sel = SEL_PRIO;
        if (a == OFS_BUSY)    d.sel = SEL_BUSY;
        for (int c = 0; c < NUM_CLS; c++) begin
            if (a == OFS_STAT_BASE + REG_AW'(STAT_STRIDE * c)) begin
                d.sel = SEL_STAT; d.cls = 2'(c);
            end
            if (a == OFS_MASK_BASE + REG_AW'(STAT_STRIDE * c)) begin
                d.sel = SEL_MASK; d.cls = 2'(c);
            end
            if (a == OFS_RAW_BASE + REG_AW'(RAW_STRIDE * c)) begin
                d.sel = SEL_RAW; d.cls = 2'(c);
            end
        end
        return d;
    endfunction

endpackage

// File: rtl/dmairq_decode.sv
module dmairq_decode
    import dmairq_pkg::*;
(
    input  logic              valid_i,
    input  logic              write_i,
    input  logic [REG_AW-1:0] addr_i,
    output logic [NUM_CLS-1:0] mask_we_o,
    output logic [NUM_CLS-1:0] clr_we_o,
    output logic              prio_we_o,
    output logic              rd_req_o,
    output reg_dec_t          dec_o
);
    always_comb begin
        dec_o     = decode_addr(addr_i);
        mask_we_o = '0;
        clr_we_o  = '0;
        prio_we_o = 1'b0;
        rd_req_o  = valid_i && !write_i;
        if (valid_i && write_i) begin
            unique case (dec_o.sel)
                SEL_MASK: mask_we_o[dec_o.cls] = 1'b1;
                SEL_RAW:  clr_we_o[dec_o.cls]  = 1'b1;
                SEL_PRIO: prio_we_o            = 1'b1;
                default:  ;
            endcase
        end
    end
endmodule

// File: rtl/dmairq_class.sv
module dmairq_class #(
    parameter int NUM_CH = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NUM_CH-1:0] ev_i,
    input  logic              mask_we_i,
    input  logic              clr_we_i,
    input  logic [NUM_CH-1:0] wdata_i,
    output logic [NUM_CH-1:0] raw_o,
    output logic [NUM_CH-1:0] mask_o,
    output logic [NUM_CH-1:0] masked_o
);
    logic [NUM_CH-1:0] raw_q, mask_q, clr_bits;

    assign clr_bits = clr_we_i ? wdata_i : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            raw_q  <= '0;
            mask_q <= '0;
        end else begin
            // a new event outranks a clear of the same bit
            raw_q <= (raw_q & ~clr_bits) | ev_i;
            if (mask_we_i) mask_q <= wdata_i;
        end
    end

    assign raw_o    = raw_q;
    assign mask_o   = mask_q;
    assign masked_o = raw_q & mask_q;
endmodule

// File: rtl/dmairq_top.sv
module dmairq_top
    import dmairq_pkg::*;
#(
    parameter int NUM_CH = 16,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NUM_CH-1:0] ev_chain_i,
    input  logic [NUM_CH-1:0] ev_node_i,
    input  logic [NUM_CH-1:0] ev_err_a_i,
    input  logic [NUM_CH-1:0] ev_err_b_i,
    input  logic [NUM_CH-1:0] busy_i,
    input  logic              reg_valid_i,
    input  logic              reg_write_i,
    input  logic [REG_AW-1:0] reg_addr_i,
    input  logic [DATA_W-1:0] reg_wdata_i,
    output logic              rd_valid_o,
    output logic [DATA_W-1:0] rd_data_o,
    output logic              irq_o
);
    logic [NUM_CLS-1:0][NUM_CH-1:0] ev_vec, raw_q, mask_q, masked;
    logic [NUM_CLS-1:0]             mask_we, clr_we;
    logic                           prio_we, rd_req;
    reg_dec_t                       dec;
    logic [NUM_CH-1:0]              summary;
    logic [DATA_W-1:0]              prio_q, rd_next, rd_data_q;
    logic                           rd_valid_q;

    assign ev_vec[CLS_CHAIN] = ev_chain_i;
    assign ev_vec[CLS_NODE]  = ev_node_i;
    assign ev_vec[CLS_ERR_A] = ev_err_a_i;
    assign ev_vec[CLS_ERR_B] = ev_err_b_i;

    dmairq_decode u_dec (
        .valid_i   (reg_valid_i),
        .write_i   (reg_write_i),
        .addr_i    (reg_addr_i),
        .mask_we_o (mask_we),
        .clr_we_o  (clr_we),
        .prio_we_o (prio_we),
        .rd_req_o  (rd_req),
        .dec_o     (dec)
    );

    for (genvar c = 0; c < NUM_CLS; c++) begin : g_cls
        dmairq_class #(.NUM_CH(NUM_CH)) u_cls (
            .clk       (clk),
            .rst       (rst),
            .ev_i      (ev_vec[c]),
            .mask_we_i (mask_we[c]),
            .clr_we_i  (clr_we[c]),
            .wdata_i   (reg_wdata_i[NUM_CH-1:0]),
            .raw_o     (raw_q[c]),
            .mask_o    (mask_q[c]),
            .masked_o  (masked[c])
        );
    end

    always_comb begin
        summary = '0;
        for (int c = 0; c < NUM_CLS; c++) summary |= masked[c];
    end

    assign irq_o = |summary;

    always_comb begin
        rd_next = '0;
        unique case (dec.sel)
            SEL_SUMMARY: rd_next[NUM_CH-1:0] = summary;
            SEL_STAT:    rd_next[NUM_CH-1:0] = masked[dec.cls];
            SEL_MASK:    rd_next[NUM_CH-1:0] = mask_q[dec.cls];
            SEL_RAW:     rd_next[NUM_CH-1:0] = raw_q[dec.cls];
            SEL_BUSY:    rd_next[NUM_CH-1:0] = busy_i;
            SEL_PRIO:    rd_next             = prio_q;
            default:     rd_next             = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            prio_q     <= '0;
            rd_valid_q <= 1'b0;
            rd_data_q  <= '0;
        end else begin
            if (prio_we) prio_q <= reg_wdata_i;
            rd_valid_q <= rd_req;
            if (rd_req) rd_data_q <= rd_next;
        end
    end

    assign rd_valid_o = rd_valid_q;
    assign rd_data_o  = rd_data_q;
endmodule

// File: rtl/dmairq_chk.sv
module dmairq_chk
    import dmairq_pkg::*;
#(
    parameter int NUM_CH = 16
) (
    input logic                           clk,
    input logic                           rst,
    input logic [NUM_CLS-1:0][NUM_CH-1:0] ev_vec,
    input logic [NUM_CLS-1:0][NUM_CH-1:0] raw_q,
    input logic [NUM_CLS-1:0][NUM_CH-1:0] mask_q,
    input logic                           irq_o,
    input logic                           reg_valid_i,
    input logic                           reg_write_i,
    input logic                           rd_valid_o
);
    // R1
    reset_clear_chk: assert property (@(posedge clk)
        $past(rst) |-> (raw_q == '0 && mask_q == '0 && !irq_o && !rd_valid_o));

    // R2 R4
    event_lands_chk: assert property (@(posedge clk) disable iff (rst)
        (ev_vec != '0) |=> ((raw_q & $past(ev_vec)) == $past(ev_vec)));

    // R2
    no_spurious_set_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((raw_q & ~$past(raw_q) & ~$past(ev_vec)) == '0));

    // R7
    irq_match_chk: assert property (@(posedge clk) disable iff (rst)
        irq_o == ((raw_q & mask_q) != '0));

    // R8
    rd_valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
        (reg_valid_i && !reg_write_i) |=> rd_valid_o);

    // R8
    rd_valid_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !(reg_valid_i && !reg_write_i) |=> !rd_valid_o);
endmodule

bind dmairq_top dmairq_chk #(.NUM_CH(NUM_CH)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .ev_vec      (ev_vec),
    .raw_q       (raw_q),
    .mask_q      (mask_q),
    .irq_o       (irq_o),
    .reg_valid_i (reg_valid_i),
    .reg_write_i (reg_write_i),
    .rd_valid_o  (rd_valid_o)
);

// File: tb/tb_dmairq_top.sv
module tb_dmairq_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] ev_chain = '0, ev_node = '0, ev_err_a = '0, ev_err_b = '0;
    logic [15:0] busy = '0;
    logic        reg_valid = 1'b0, reg_write = 1'b0;
    logic [11:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic        rd_valid_o, irq_o;
    logic [31:0] rd_data_o;

    int checks = 0, fails = 0;
    bit done = 1'b0;

    logic [15:0] m_raw [4];
    logic [15:0] m_mask[4];
    logic [31:0] m_prio;

    always #5 clk = ~clk;

    dmairq_top dut (
        .clk(clk), .rst(rst),
        .ev_chain_i(ev_chain), .ev_node_i(ev_node),
        .ev_err_a_i(ev_err_a), .ev_err_b_i(ev_err_b),
        .busy_i(busy),
        .reg_valid_i(reg_valid), .reg_write_i(reg_write),
        .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata),
        .rd_valid_o(rd_valid_o), .rd_data_o(rd_data_o), .irq_o(irq_o)
    );

    function automatic logic [11:0] raw_addr(int c);  return 12'h600 + 12'(8 * c); endfunction
    function automatic logic [11:0] mask_addr(int c); return 12'h018 + 12'(4 * c); endfunction
    function automatic logic [11:0] stat_addr(int c); return 12'h004 + 12'(4 * c); endfunction

    function automatic logic [15:0] exp_summary();
        logic [15:0] s = '0;
        for (int c = 0; c < 4; c++) s |= m_raw[c] & m_mask[c];
        return s;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_valid = 1'b1; reg_write = 1'b0; reg_addr = a;
        @(negedge clk);
        reg_valid = 1'b0;
        d = rd_data_o;
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] v);
        @(negedge clk);
        reg_valid = 1'b1; reg_write = 1'b1; reg_addr = a; reg_wdata = v;
        @(negedge clk);
        reg_valid = 1'b0; reg_write = 1'b0;
    endtask

    task automatic set_ev(input int c, input logic [15:0] v);
        case (c)
            0: ev_chain = v;
            1: ev_node  = v;
            2: ev_err_a = v;
            default: ev_err_b = v;
        endcase
    endtask

    task automatic pulse(input int c, input logic [15:0] v);
        @(negedge clk);
        set_ev(c, v);
        @(negedge clk);
        set_ev(c, '0);
        m_raw[c] |= v;
    endtask

    task automatic check_all(input string req);
        logic [31:0] d;
        for (int c = 0; c < 4; c++) begin
            rd(raw_addr(c), d);  chk({req, " latch"}, d, {16'h0, m_raw[c]});
            rd(mask_addr(c), d); chk({req, " mask"}, d, {16'h0, m_mask[c]});
            rd(stat_addr(c), d); chk({req, " masked"}, d, {16'h0, m_raw[c] & m_mask[c]});
        end
        rd(12'h000, d); chk({req, " summary"}, d, {16'h0, exp_summary()});
        chk({req, " irq"}, {31'h0, irq_o}, {31'h0, exp_summary() != 0});
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        for (int c = 0; c < 4; c++) begin m_raw[c] = '0; m_mask[c] = '0; end
        m_prio = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk("R1 irq", {31'h0, irq_o}, 32'h0);
        chk("R1 rd_valid", {31'h0, rd_valid_o}, 32'h0);
        check_all("R1");
        rd(12'h688, d); chk("R1 prio", d, 32'h0);

        // R2 sweep every kind and channel, one bit at a time
        for (int c = 0; c < 4; c++)
            for (int i = 0; i < 16; i++) begin
                pulse(c, 16'h1 << i);
                rd(raw_addr(c), d);
                chk("R2 latch sweep", d, {16'h0, m_raw[c]});
                chk("R7 irq masked off", {31'h0, irq_o}, 32'h0);
            end

        // R5 R6 R7 mask patterns per kind
        for (int p = 0; p < 4; p++) begin
            for (int c = 0; c < 4; c++) begin
                m_mask[c] = (p == 3) ? 16'hffff : 16'(16'h1 << ((c * 5 + p * 3) % 16));
                wr(mask_addr(c), {16'hdead, m_mask[c]});
            end
            check_all("R5 R6 R7 masks");
        end

        // R3 partial clear, and a write of zero
        wr(raw_addr(0), 32'h0000a5a5); m_raw[0] &= ~16'ha5a5;
        wr(raw_addr(1), 32'h0);
        check_all("R3 R12 clear");
        // R7 irq off when everything enabled is cleared
        for (int c = 0; c < 4; c++) begin wr(raw_addr(c), 32'hffff); m_raw[c] = '0; end
        check_all("R7 all cleared");

        // R4 event and clear on the same bit in the same cycle
        m_raw[2] = 16'h00f0;
        pulse(2, 16'h00f0);
        @(negedge clk);
        reg_valid = 1'b1; reg_write = 1'b1; reg_addr = raw_addr(2); reg_wdata = 32'hffff;
        ev_err_a = 16'h0010;
        @(negedge clk);
        reg_valid = 1'b0; reg_write = 1'b0; ev_err_a = '0;
        m_raw[2] = 16'h0010;
        rd(raw_addr(2), d); chk("R4 event wins", d, 32'h0010);
        check_all("R4 R12");

        // R8 latency and value at the request edge
        @(negedge clk);
        reg_valid = 1'b1; reg_write = 1'b0; reg_addr = raw_addr(3);
        ev_err_b = 16'h8000;
        @(negedge clk);
        reg_valid = 1'b0; ev_err_b = '0; m_raw[3] |= 16'h8000;
        chk("R8 valid", {31'h0, rd_valid_o}, 32'h1);
        chk("R8 data at request edge", rd_data_o, 32'h0);
        @(negedge clk);
        chk("R8 valid one cycle", {31'h0, rd_valid_o}, 32'h0);
        rd(raw_addr(3), d); chk("R8 later read", d, {16'h0, m_raw[3]});
        @(negedge clk);
        reg_valid = 1'b1; reg_write = 1'b1; reg_addr = 12'h688; reg_wdata = 32'h0;
        @(negedge clk);
        reg_valid = 1'b0; reg_write = 1'b0;
        chk("R8 no valid on write", {31'h0, rd_valid_o}, 32'h0);

        // R9 busy flags
        for (int k = 0; k < 4; k++) begin
            busy = 16'h1111 << k;
            rd(12'h690, d); chk("R9 busy", d, {16'h0, 16'h1111 << k});
        end
        busy = '0;

        // R10 priority word
        wr(12'h688, 32'hcafe1234); m_prio = 32'hcafe1234;
        rd(12'h688, d); chk("R10 prio readback", d, m_prio);
        check_all("R10 no side effect");

        // R11 writes to read-only views, unmapped reads
        wr(12'h000, 32'hffffffff);
        for (int c = 0; c < 4; c++) wr(stat_addr(c), 32'hffffffff);
        wr(12'h690, 32'hffffffff);
        check_all("R11 read-only writes");
        rd(12'h100, d); chk("R11 unmapped", d, 32'h0);
        rd(12'h604, d); chk("R11 unmapped gap", d, 32'h0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule